// File: doc/BRIEF.md
# Burst Address Counter

This block holds the internal access address for one port of a synchronous burst memory. At every rising clock edge it picks the next address from one of four sources. An active-low clear forces it to zero. An active-low load strobe takes the external address. An active-low advance input adds one to the stored address. When none of these are asserted, the stored address is kept. The registered result drives the storage array directly, so the address chosen at an edge is the one accessed in the cycle that edge opens.

The control inputs are the only inputs that move the counter. The block has no chip-select input, so the counter loads, clears and advances whether or not the port is selected. A clear costs no dead cycle: the access at address zero happens in the same cycle the clear takes effect. The cycle after that can already advance to address one.

Top module: `burst_addr_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `addr_q` is 0 after that edge, whatever the other inputs are.
- R2: When `clr_n` is 0 at a rising edge and `rst` is low, `addr_q` becomes 0, whatever `load_n`, `adv_n` and `ext_addr` are.
- R3: When `clr_n` is 1 and `load_n` is 0 at a rising edge, `addr_q` becomes the value of `ext_addr` sampled at that edge, whatever `adv_n` is.
- R4: When `clr_n`, `load_n` and `adv_n` are all 1 at a rising edge, `addr_q` keeps its value.
- R5: When `clr_n` is 1, `load_n` is 1 and `adv_n` is 0 at a rising edge, `addr_q` becomes its previous value plus one.
- R6: Advancing from the all-ones address gives address 0.
- R7: No idle cycle follows a clear or a load. An advance in the very next cycle moves from the new address at once: a clear then an advance gives 1, and a load of A then an advance gives A+1.
- R8: The address width is the parameter `ADDR_W`, 17 by default (128K locations).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst | input | 1 | Synchronous active-high power-on reset |
| clr_n | input | 1 | Active-low counter clear, highest priority |
| load_n | input | 1 | Active-low strobe that loads `ext_addr` |
| adv_n | input | 1 | Active-low advance (increment) enable |
| ext_addr | input | ADDR_W | External address |
| addr_q | output | ADDR_W | Registered internal access address |

## Verification
The properties assume that all three controls and the external address are at known levels at every edge after reset. They also assume that reset is high at the first edge, so that `$past` of the address is defined. The bench holds reset across its first edges and changes inputs only on the falling clock edge, so every sampled control is settled and known. It drives a 4-bit instance through every combination of the three controls, from every starting address and with every external address. This covers the wrap at all-ones and the back-to-back clear/advance and load/advance sequences.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [1:0] {
    OP_CLR  = 2'd0,
    OP_LOAD = 2'd1,
    OP_HOLD = 2'd2,
    OP_INC  = 2'd3
  } bac_op_t;
endpackage

// File: rtl/bac_op_decode.sv
// Priority select of the address source: clear, then load, then advance, else hold.
module bac_op_decode
  import bac_pkg::*;
(
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    adv_n,
  output bac_op_t op
);
  always_comb begin
    if (!clr_n)       op = OP_CLR;
    else if (!load_n) op = OP_LOAD;
    else if (!adv_n)  op = OP_INC;
    else              op = OP_HOLD;
  end
endmodule

// File: rtl/bac_next_addr.sv
// Next-address mux; the incrementer wraps modulo 2**AW.
module bac_next_addr
  import bac_pkg::*;
#(
  parameter int AW = 17
) (
  input  bac_op_t         op,
  input  logic [AW-1:0]   ext_addr,
  input  logic [AW-1:0]   cur_addr,
  output logic [AW-1:0]   nxt_addr
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] inc_addr;
  assign inc_addr = cur_addr + ONE;

  always_comb begin
    unique case (op)
      OP_CLR:  nxt_addr = '0;
      OP_LOAD: nxt_addr = ext_addr;
      OP_INC:  nxt_addr = inc_addr;
      default: nxt_addr = cur_addr;
    endcase
  end
endmodule

// File: rtl/bac_addr_reg.sv
// Address register with synchronous active-high reset.
module bac_addr_reg #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
  import bac_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_n,
  input  logic              load_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] addr_q
);
  bac_op_t           op;
  logic [ADDR_W-1:0] nxt_addr;

  bac_op_decode u_dec (
    .clr_n  (clr_n),
    .load_n (load_n),
    .adv_n  (adv_n),
    .op     (op)
  );

  bac_next_addr #(.AW(ADDR_W)) u_nxt (
    .op       (op),
    .ext_addr (ext_addr),
    .cur_addr (addr_q),
    .nxt_addr (nxt_addr)
  );

  bac_addr_reg #(.AW(ADDR_W)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (nxt_addr),
    .q   (addr_q)
  );
endmodule

// File: rtl/bac_checker.sv
module bac_checker #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          clr_n,
  input logic          load_n,
  input logic          adv_n,
  input logic [AW-1:0] ext_addr,
  input logic [AW-1:0] addr_q
);
  localparam logic [AW-1:0] ONE = AW'(1);

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> addr_q == '0);

  a_r2_clear_wins: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> addr_q == '0);

  a_r3_load_ext: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !load_n) |=> addr_q == $past(ext_addr));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && adv_n) |=> $stable(addr_q));

  a_r5_advance: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && !adv_n) |=> addr_q == $past(addr_q) + ONE);

  a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && !adv_n && addr_q == '1) |=> addr_q == '0);
endmodule

bind burst_addr_counter bac_checker #(.AW(ADDR_W)) u_bac_chk (
  .clk      (clk),
  .rst      (rst),
  .clr_n    (clr_n),
  .load_n   (load_n),
  .adv_n    (adv_n),
  .ext_addr (ext_addr),
  .addr_q   (addr_q)
);

// File: tb/test_burst_addr_counter.sv
`timescale 1ns/1ps
module test_burst_addr_counter;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clr_n = 1'b1;
  logic          load_n = 1'b1;
  logic          adv_n = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] addr_q;

  logic [AW-1:0] exp_a = '0;
  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  burst_addr_counter #(.ADDR_W(AW)) i_burst_addr_counter (
    .clk, .rst, .clr_n, .load_n, .adv_n, .ext_addr, .addr_q
  );

  task automatic check(input string req);
    vectors++;
    if (addr_q !== exp_a) begin
      fails++;
      $display("FAIL %s: addr_q=%0d expected=%0d", req, addr_q, exp_a);
    end
  endtask

  // Apply one edge: inputs set on the falling edge, result checked after the rising edge.
  task automatic step(input bit r, input bit c, input bit l, input bit a,
                      input logic [AW-1:0] e, input string req);
    @(negedge clk);
    rst = r; clr_n = c; load_n = l; adv_n = a; ext_addr = e;
    if (r)       exp_a = '0;
    else if (!c) exp_a = '0;
    else if (!l) exp_a = e;
    else if (!a) exp_a = exp_a + AW'(1);
    @(posedge clk);
    #1;
    check(req);
  endtask

  function automatic string tag_of(input bit c, input bit l, input bit a,
                                   input logic [AW-1:0] start);
    if (!c) return "R2";
    if (!l) return "R3";
    if (!a) return (start == '1) ? "R6" : "R5";
    return "R4";
  endfunction

  initial begin
    // R1: reset state, with other controls asking for a load
    step(1, 1, 0, 0, 4'd9, "R1");
    step(1, 1, 1, 1, 4'd0, "R1");
    // R8: small width instance wraps at 2**AW
    for (int s = 0; s < N; s++) begin
      for (int k = 0; k < 8; k++) begin
        for (int e = 0; e < N; e++) begin
          step(0, 1, 0, 1, AW'(s), "R3");
          step(0, k[2], k[1], k[0], AW'(e), tag_of(k[2], k[1], k[0], AW'(s)));
        end
      end
    end
    // R7: clear then advance without a gap
    step(0, 1, 0, 1, 4'd11, "R3");
    step(0, 0, 0, 0, 4'd7, "R2");
    step(0, 1, 1, 0, 4'd3, "R7");
    step(0, 1, 1, 0, 4'd3, "R7");
    // R7: load then advance without a gap
    step(0, 1, 0, 0, 4'd14, "R3");
    step(0, 1, 1, 0, 4'd0, "R7");
    step(0, 1, 1, 0, 4'd0, "R6");
    // R4: a long hold keeps the address
    for (int i = 0; i < 5; i++) step(0, 1, 1, 1, AW'(i), "R4");
    // R8: a full run of advances returns to the start
    step(0, 1, 0, 1, 4'd5, "R3");
    for (int i = 0; i < N; i++) step(0, 1, 1, 0, 4'd0, "R8");
    // R1: reset in mid-run
    step(1, 1, 1, 0, 4'd0, "R1");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: addr_q=%0d expected=finish", addr_q);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule